// File: doc/BRIEF.md
# Four-bit character display bring-up and transfer sequencer

This block sits on the host side of a character display module with an HD44780-style instruction set and drives it over a four-wire parallel data bus. It also drives a register-select line, a read/write line and an enable strobe. After reset it waits out the display's power-on settling time. It then runs the nibble-level synchronisation that forces the display into four-bit mode and sends the configuration bytes that the static configuration inputs select: line count, font height, address direction and scrolling.

Once bring-up is over, the host hands over one byte at a time on a valid/ready handshake, and a flag marks each byte as an instruction or as display data. The sequencer splits each byte into two nibbles, upper nibble first, and strobes each one with a parameterised setup, enable-high and hold phase. It then stays busy for the execution time of that byte. Clear and home instructions get the long wait. Everything else gets the short one.

All waits are cycle counts derived from a clock-frequency parameter and rounded up. No wait is ever shorter than the time it stands for.

Top module: `chlcd_seq`

## Requirements
- R1: At reset, `lcd_en` and `req_ready` are 0. The first enable pulse rises no earlier than ceil(15 ms × CLK_HZ) + SETUP_CYC cycles after reset release.
- R2: The first three strobed nibbles are 0x3 with `lcd_rs`=0. Between the fall of the first and the next rise there are at least HOLD_CYC + ceil(4.1 ms × CLK_HZ) + SETUP_CYC cycles. After the second the minimum is HOLD_CYC + ceil(100 us × CLK_HZ) + SETUP_CYC.
- R3: The fourth nibble is a lone 0x2. After it come four instruction bytes, each as an upper nibble then a lower nibble:
  - {0x2, two_line, tall_font, 0, 0}
  - 0x08
  - 0x01
  - {0x0, 0, 1, addr_inc, scroll}
- R4: Within one byte, the lower nibble's enable rises exactly HOLD_CYC + SETUP_CYC cycles after the upper nibble's enable falls.
- R5: `lcd_en` stays high for exactly HIGH_CYC cycles. `lcd_db` and `lcd_rs` are valid at least SETUP_CYC cycles before the rise, stay unchanged while the enable is high, and hold for HOLD_CYC cycles after the fall.
- R6: `lcd_rw` is always 0: every transfer is a write.
- R7: `req_ready` stays 0 until bring-up ends, and it drops for the cycle after an acceptance. A byte accepted on `req_valid` && `req_ready` is strobed with `lcd_rs` equal to `req_rs` (0 instruction, 1 data). `req_ready` is never high while the enable is high.
- R8: After a byte's last fall, the next rise or the return of `req_ready` waits at least HOLD_CYC + the execution time. The execution time is ceil(1.52 ms × CLK_HZ) for an instruction (`req_rs`=0) whose bits 7:2 are zero and bits 1:0 are not both zero. Every other byte uses ceil(38 us × CLK_HZ).
- R9: Every wait count is the wait time multiplied by CLK_HZ and rounded up to a whole cycle. The same short count follows the third 0x3 nibble and the lone 0x2 nibble.
- R10: A `req_valid` pulse that starts and ends while `req_ready` is 0 produces no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_two_line | input | 1 | Selects two display lines in the function-set byte |
| cfg_tall_font | input | 1 | Selects the taller character cell |
| cfg_addr_inc | input | 1 | Address counter moves up after each access |
| cfg_scroll | input | 1 | Display shifts on each data write |
| req_valid | input | 1 | Host byte request |
| req_rs | input | 1 | 0 instruction, 1 data |
| req_byte | input | 8 | Byte to send |
| req_ready | output | 1 | Sequencer can accept a byte |
| lcd_rs | output | 1 | Register select to the display |
| lcd_rw | output | 1 | Read/write select, held at write |
| lcd_en | output | 1 | Enable strobe, data taken on its fall |
| lcd_db | output | 4 | Upper four data lines |

## Verification
The assertions assume that the configuration inputs stay constant from reset onward, because the bring-up bytes are built from them at send time. They also assume that the host keeps a request stable until it is accepted. The stimulus sets the configuration once, before reset release. It changes `req_valid`, `req_rs` and `req_byte` only on falling clock edges, and it lowers `req_valid` only after an observed acceptance. The one exception is a deliberate single-cycle pulse during a busy period, used to probe R10.

// File: rtl/chlcd_pkg.sv
package chlcd_pkg;

  // wait classes selectable per bring-up step
  typedef enum logic [1:0] {
    W_SHORT = 2'd0,
    W_SYNC2 = 2'd1,
    W_SYNC1 = 2'd2,
    W_LONG  = 2'd3
  } wsel_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HIGH  = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    M_POWER = 3'd0,
    M_ISSUE = 3'd1,
    M_SEND  = 3'd2,
    M_DELAY = 3'd3,
    M_READY = 3'd4
  } mode_e;

  typedef struct packed {
    logic  single;   // only code[7:4] is strobed
    logic [7:0] code;
    wsel_e wsel;
  } step_t;

  localparam int unsigned INIT_STEPS = 8;

  // microseconds to clock cycles, rounded up
  function automatic int unsigned us_to_cycles(input longint unsigned hz,
                                               input longint unsigned us);
    longint unsigned prod;
    prod = hz * us;
    return 32'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

  function automatic step_t init_step(input logic [2:0] idx,
                                      input logic two_line,
                                      input logic tall_font,
                                      input logic addr_inc,
                                      input logic scroll);
    step_t s;
    s.single = 1'b0;
    s.code   = 8'h00;
    s.wsel   = W_SHORT;
    case (idx)
      3'd0: begin s.single = 1'b1; s.code = 8'h30; s.wsel = W_SYNC1; end
      3'd1: begin s.single = 1'b1; s.code = 8'h30; s.wsel = W_SYNC2; end
      3'd2: begin s.single = 1'b1; s.code = 8'h30; end
      3'd3: begin s.single = 1'b1; s.code = 8'h20; end
      3'd4: s.code = {4'h2, two_line, tall_font, 2'b00};
      3'd5: s.code = 8'h08;
      3'd6: begin s.code = 8'h01; s.wsel = W_LONG; end
      default: s.code = {6'b000001, addr_inc, scroll};
    endcase
    return s;
  endfunction

  // clear or home instruction: long execution
  function automatic logic is_slow_cmd(input logic rs, input logic [7:0] b);
    return (!rs) && (b[7:2] == 6'd0) && (b[1:0] != 2'd0);
  endfunction

endpackage

// File: rtl/chlcd_rst_sync.sv
module chlcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/chlcd_delay_timer.sv
module chlcd_delay_timer #(
  parameter int unsigned CW       = 20,
  parameter int unsigned RST_LOAD = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(RST_LOAD);
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0) && !load;
endmodule

// File: rtl/chlcd_init_steps.sv
module chlcd_init_steps import chlcd_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  input  logic  cfg_two_line,
  input  logic  cfg_tall_font,
  input  logic  cfg_addr_inc,
  input  logic  cfg_scroll,
  output step_t step,
  output logic  last
);
  localparam int unsigned IW = $clog2(INIT_STEPS);

  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (advance && !last) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign last = (idx_q == IW'(INIT_STEPS - 1));
  assign step = init_step(3'(idx_q), cfg_two_line, cfg_tall_font,
                          cfg_addr_inc, cfg_scroll);
endmodule

// File: rtl/chlcd_nibble_tx.sv
module chlcd_nibble_tx import chlcd_pkg::*; #(
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned HIGH_CYC  = 12,
  parameter int unsigned HOLD_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       single,
  input  logic       rs,
  input  logic [7:0] code,
  output logic       done,
  output logic       bus_en,
  output logic       bus_rs,
  output logic [3:0] bus_db
);
  localparam int unsigned PMAX_SH = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int unsigned PMAX    = (PMAX_SH > HIGH_CYC) ? PMAX_SH : HIGH_CYC;
  localparam int unsigned PCW     = $clog2(PMAX + 1);
  localparam logic [PCW-1:0] SETUP_LD = PCW'(SETUP_CYC - 1);
  localparam logic [PCW-1:0] HIGH_LD  = PCW'(HIGH_CYC - 1);
  localparam logic [PCW-1:0] HOLD_LD  = PCW'(HOLD_CYC - 1);

  phase_e         ph_q, ph_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic           lo_pend_q, lo_pend_d;
  logic [3:0]     lo_nib_q, lo_nib_d;
  logic           rs_q, rs_d;
  logic [3:0]     db_q, db_d;
  logic           en_q, en_d;

  always_comb begin
    ph_d      = ph_q;
    pcnt_d    = pcnt_q;
    lo_pend_d = lo_pend_q;
    lo_nib_d  = lo_nib_q;
    rs_d      = rs_q;
    db_d      = db_q;
    done      = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d      = PH_SETUP;
          pcnt_d    = SETUP_LD;
          db_d      = code[7:4];
          lo_nib_d  = code[3:0];
          rs_d      = rs;
          lo_pend_d = !single;
        end
      end
      PH_SETUP: begin
        if (pcnt_q == '0) begin
          ph_d   = PH_HIGH;
          pcnt_d = HIGH_LD;
        end else begin
          pcnt_d = pcnt_q - 1'b1;
        end
      end
      PH_HIGH: begin
        if (pcnt_q == '0) begin
          ph_d   = PH_HOLD;
          pcnt_d = HOLD_LD;
        end else begin
          pcnt_d = pcnt_q - 1'b1;
        end
      end
      default: begin
        if (pcnt_q != '0) begin
          pcnt_d = pcnt_q - 1'b1;
        end else if (lo_pend_q) begin
          ph_d      = PH_SETUP;
          pcnt_d    = SETUP_LD;
          db_d      = lo_nib_q;
          lo_pend_d = 1'b0;
        end else begin
          ph_d = PH_IDLE;
          done = 1'b1;
        end
      end
    endcase
    en_d = (ph_d == PH_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      pcnt_q    <= '0;
      lo_pend_q <= 1'b0;
      lo_nib_q  <= '0;
      rs_q      <= 1'b0;
      db_q      <= '0;
      en_q      <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      pcnt_q    <= pcnt_d;
      lo_pend_q <= lo_pend_d;
      lo_nib_q  <= lo_nib_d;
      rs_q      <= rs_d;
      db_q      <= db_d;
      en_q      <= en_d;
    end
  end

  assign bus_en = en_q;
  assign bus_rs = rs_q;
  assign bus_db = db_q;
endmodule

// File: rtl/chlcd_seq.sv
module chlcd_seq import chlcd_pkg::*; #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned HIGH_CYC  = 12,
  parameter int unsigned HOLD_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_two_line,
  input  logic       cfg_tall_font,
  input  logic       cfg_addr_inc,
  input  logic       cfg_scroll,
  input  logic       req_valid,
  input  logic       req_rs,
  input  logic [7:0] req_byte,
  output logic       req_ready,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [3:0] lcd_db
);
  localparam int unsigned CYC_PWR   = us_to_cycles(CLK_HZ, 15000);
  localparam int unsigned CYC_SYNC1 = us_to_cycles(CLK_HZ, 4100);
  localparam int unsigned CYC_SYNC2 = us_to_cycles(CLK_HZ, 100);
  localparam int unsigned CYC_LONG  = us_to_cycles(CLK_HZ, 1520);
  localparam int unsigned CYC_SHORT = us_to_cycles(CLK_HZ, 38);
  localparam int unsigned TCW       = $clog2(CYC_PWR + 1);

  logic          rst_i_n;
  mode_e         mode_q, mode_d;
  logic          init_q, init_d;
  logic          hrs_q, hrs_d;
  logic [7:0]    hbyte_q, hbyte_d;
  logic          tx_start, tx_done, tx_single, tx_rs;
  logic [7:0]    tx_code;
  logic          tmr_load, tmr_expired;
  logic [TCW-1:0] tmr_val, init_wait, host_wait;
  logic          step_adv, step_last;
  step_t         step;

  chlcd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  chlcd_delay_timer #(.CW(TCW), .RST_LOAD(CYC_PWR)) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  chlcd_init_steps u_steps (
    .clk(clk), .rst_n(rst_i_n), .advance(step_adv),
    .cfg_two_line(cfg_two_line), .cfg_tall_font(cfg_tall_font),
    .cfg_addr_inc(cfg_addr_inc), .cfg_scroll(cfg_scroll),
    .step(step), .last(step_last)
  );

  chlcd_nibble_tx #(
    .SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_tx (
    .clk(clk), .rst_n(rst_i_n), .start(tx_start), .single(tx_single),
    .rs(tx_rs), .code(tx_code), .done(tx_done),
    .bus_en(lcd_en), .bus_rs(lcd_rs), .bus_db(lcd_db)
  );

  // byte source: bring-up step or captured host request
  assign tx_single = init_q ? step.single : 1'b0;
  assign tx_rs     = init_q ? 1'b0 : hrs_q;
  assign tx_code   = init_q ? step.code : hbyte_q;

  always_comb begin
    case (step.wsel)
      W_SYNC1: init_wait = TCW'(CYC_SYNC1);
      W_SYNC2: init_wait = TCW'(CYC_SYNC2);
      W_LONG:  init_wait = TCW'(CYC_LONG);
      default: init_wait = TCW'(CYC_SHORT);
    endcase
    host_wait = is_slow_cmd(hrs_q, hbyte_q) ? TCW'(CYC_LONG) : TCW'(CYC_SHORT);
  end

  always_comb begin
    mode_d   = mode_q;
    init_d   = init_q;
    hrs_d    = hrs_q;
    hbyte_d  = hbyte_q;
    tx_start = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    step_adv = 1'b0;
    case (mode_q)
      M_POWER: if (tmr_expired) mode_d = M_ISSUE;
      M_ISSUE: begin
        tx_start = 1'b1;
        mode_d   = M_SEND;
      end
      M_SEND: begin
        if (tx_done) begin
          tmr_load = 1'b1;
          tmr_val  = init_q ? init_wait : host_wait;
          mode_d   = M_DELAY;
        end
      end
      M_DELAY: begin
        if (tmr_expired) begin
          if (init_q && !step_last) begin
            step_adv = 1'b1;
            mode_d   = M_ISSUE;
          end else begin
            init_d = 1'b0;
            mode_d = M_READY;
          end
        end
      end
      M_READY: begin
        if (req_valid) begin
          hrs_d   = req_rs;
          hbyte_d = req_byte;
          mode_d  = M_ISSUE;
        end
      end
      default: mode_d = M_POWER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mode_q  <= M_POWER;
      init_q  <= 1'b1;
      hrs_q   <= 1'b0;
      hbyte_q <= '0;
    end else begin
      mode_q  <= mode_d;
      init_q  <= init_d;
      hrs_q   <= hrs_d;
      hbyte_q <= hbyte_d;
    end
  end

  assign req_ready = (mode_q == M_READY);
  assign lcd_rw    = 1'b0;
endmodule

// File: rtl/chlcd_seq_chk.sv
module chlcd_seq_chk import chlcd_pkg::*; #(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned HIGH_CYC = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       lcd_rs,
  input logic       lcd_en,
  input logic [3:0] lcd_db
);
  localparam int unsigned CYC_PWR = us_to_cycles(CLK_HZ, 15000);

  logic [31:0] age_q;
  logic [15:0] hcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      hcnt_q <= '0;
    end else begin
      age_q  <= (age_q < CYC_PWR) ? age_q + 1'b1 : age_q;
      hcnt_q <= lcd_en ? hcnt_q + 1'b1 : 16'd0;
    end
  end

  p_powerup_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q < CYC_PWR) |-> (!lcd_en && !req_ready));

  p_enable_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_en && $past(lcd_en)) |-> (hcnt_q == 16'(HIGH_CYC)));

  p_bus_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lcd_en) |-> ($stable(lcd_db) && $stable(lcd_rs)));

  p_ready_bus_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !lcd_en);

  p_accept_drops_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind chlcd_seq chlcd_seq_chk #(.CLK_HZ(CLK_HZ), .HIGH_CYC(HIGH_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .lcd_rs(lcd_rs), .lcd_en(lcd_en), .lcd_db(lcd_db)
);

// File: tb/chlcd_seq_tb_top.sv
module chlcd_seq_tb_top;
  localparam int HZ = 200_000;
  localparam int SU = 2;
  localparam int HI = 3;
  localparam int HO = 2;
  localparam int BIG = 1_000_000_000;

  function automatic int cyc(input longint us);
    return int'((longint'(HZ) * us + 64'd999_999) / 64'd1_000_000);
  endfunction

  localparam int T_PWR   = cyc(15000);
  localparam int T_SYNC1 = cyc(4100);
  localparam int T_SYNC2 = cyc(100);
  localparam int T_LONG  = cyc(1520);
  localparam int T_SHORT = cyc(38);

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_rs, req_ready;
  logic [7:0] req_byte;
  logic lcd_rs, lcd_rw, lcd_en;
  logic [3:0] lcd_db;

  always #10 clk = ~clk;

  chlcd_seq #(.CLK_HZ(HZ), .SETUP_CYC(SU), .HIGH_CYC(HI), .HOLD_CYC(HO)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_two_line(1'b1), .cfg_tall_font(1'b0), .cfg_addr_inc(1'b1), .cfg_scroll(1'b0),
    .req_valid(req_valid), .req_rs(req_rs), .req_byte(req_byte), .req_ready(req_ready),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en), .lcd_db(lcd_db)
  );

  typedef struct {
    bit    rs;
    bit [3:0] nib;
    int    gap;
    bit    exact;
    int    rdy;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic push_nib(input bit rs, input bit [3:0] nib, input int gap,
                          input bit exact, input int rdy, input string tag);
    exp_t e;
    e.rs = rs; e.nib = nib; e.gap = gap; e.exact = exact; e.rdy = rdy; e.tag = tag;
    q.push_back(e);
  endtask

  // upper nibble, then lower nibble with the byte's execution wait
  task automatic push_byte(input bit rs, input bit [7:0] b, input int d,
                           input bit rdy_ok, input string tag);
    push_nib(rs, b[7:4], HO + SU, 1'b1, BIG, "R4");
    push_nib(rs, b[3:0], HO + d + SU, 1'b0, rdy_ok ? HO + d : BIG, tag);
  endtask

  // reference monitor, sampled on the falling clock edge
  bit prev_en, prev_rs, prev_rdy;
  bit [3:0] prev_db;
  int lowrun, hirun, stab, need_gap, need_rdy;
  bit need_exact;
  string need_tag;

  always @(negedge clk) begin
    if (mon_on) begin
      bit changed;
      changed = (lcd_db != prev_db) || (lcd_rs != prev_rs);
      stab = changed ? 1 : stab + 1;
      if (changed)
        chk(!lcd_en && lowrun >= HO, "R5", "data changed inside hold window, low cycles",
            lowrun, HO);
      if (lcd_en && !prev_en) begin
        chk(stab > SU, "R5", "setup cycles before enable rise", stab - 1, SU);
        chk(lcd_rw == 1'b0, "R6", "rw at enable rise", lcd_rw, 0);
        chk(!req_ready, "R7", "ready while enable high", req_ready, 0);
        if (need_exact)
          chk(lowrun == need_gap, need_tag, "low cycles before rise", lowrun, need_gap);
        else
          chk(lowrun >= need_gap, need_tag, "low cycles before rise (min)", lowrun, need_gap);
        hirun = 1;
      end else if (lcd_en) begin
        hirun++;
      end
      if (!lcd_en && prev_en) begin
        chk(hirun == HI, "R5", "enable high cycles", hirun, HI);
        chk(lcd_rw == 1'b0, "R6", "rw at enable fall", lcd_rw, 0);
        if (q.size() == 0) begin
          chk(1'b0, "R10", "unexpected nibble strobed", lcd_db, -1);
          need_gap = 0; need_exact = 0; need_rdy = 0; need_tag = "R10";
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(lcd_rs == e.rs, e.tag, "rs of strobed nibble", lcd_rs, e.rs);
          chk(lcd_db == e.nib, e.tag, "strobed nibble", lcd_db, e.nib);
          need_gap = e.gap; need_exact = e.exact; need_rdy = e.rdy; need_tag = e.tag;
        end
        lowrun = 1;
      end else if (!lcd_en) begin
        lowrun++;
      end
      if (req_ready && !prev_rdy)
        chk(lowrun >= need_rdy, "R8", "cycles from last fall to ready", lowrun, need_rdy);
      prev_en = lcd_en; prev_rs = lcd_rs; prev_db = lcd_db; prev_rdy = req_ready;
    end
  end

  task automatic send(input bit rs, input bit [7:0] b, input int d, input string tag);
    push_byte(rs, b, d, 1'b1, tag);
    req_rs = rs; req_byte = b; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired: got %0d expected %0d", 0, 1);
      report();
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_rs = 1'b0; req_byte = 8'h00;
    repeat (4) @(negedge clk);
    chk(!lcd_en, "R1", "enable in reset", lcd_en, 0);
    chk(!req_ready, "R1", "ready in reset", req_ready, 0);
    chk(!lcd_rw, "R6", "rw in reset", lcd_rw, 0);

    // bring-up expectations (two lines, short font, increment, no scroll)
    push_nib(1'b0, 4'h3, HO + T_SYNC1 + SU, 1'b0, BIG, "R2");
    push_nib(1'b0, 4'h3, HO + T_SYNC2 + SU, 1'b0, BIG, "R2");
    push_nib(1'b0, 4'h3, HO + T_SHORT + SU, 1'b0, BIG, "R9");
    push_nib(1'b0, 4'h2, HO + T_SHORT + SU, 1'b0, BIG, "R9");
    push_byte(1'b0, 8'h28, T_SHORT, 1'b0, "R3");
    push_byte(1'b0, 8'h08, T_SHORT, 1'b0, "R3");
    push_byte(1'b0, 8'h01, T_LONG,  1'b0, "R3");
    push_byte(1'b0, 8'h06, T_SHORT, 1'b1, "R3");

    prev_en = lcd_en; prev_rs = lcd_rs; prev_db = lcd_db; prev_rdy = req_ready;
    lowrun = 0; hirun = 0; stab = 0;
    need_gap = T_PWR + SU; need_exact = 1'b0; need_rdy = BIG; need_tag = "R1";
    rst_n = 1'b1;
    mon_on = 1'b1;

    send(1'b1, 8'h41, T_SHORT, "R7");
    send(1'b0, 8'h01, T_LONG, "R8");
    // R10: one-cycle request while busy
    chk(!req_ready, "R10", "ready low before stray pulse", req_ready, 0);
    req_valid = 1'b1; req_rs = 1'b1; req_byte = 8'hFF;
    @(negedge clk);
    req_valid = 1'b0;
    send(1'b0, 8'h02, T_LONG, "R8");
    send(1'b0, 8'hC5, T_SHORT, "R8");
    send(1'b1, 8'hA5, T_SHORT, "R7");
    send(1'b1, 8'h5A, T_SHORT, "R7");
    send(1'b0, 8'h03, T_LONG, "R8");
    send(1'b0, 8'h04, T_SHORT, "R8");
    send(1'b1, 8'h00, T_SHORT, "R8");

    while (!req_ready) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R7", "nibbles left unsent", q.size(), 0);
    chk(req_ready, "R7", "ready when idle", req_ready, 1);
    chk(!lcd_en, "R10", "no strobe when idle", lcd_en, 0);
    finished = 1'b1;
    report();
  end
endmodule